// File: doc/BRIEF.md
# Move-Wide Immediate Execution Unit

This unit carries out the move-wide group of register-load operations for a 64-bit core. Each operation supplies a 16-bit immediate and a lane number that places it in one of the 16-bit lanes of the destination. It also supplies a merge mode, a destination width flag and the current destination value. The unit returns the new destination value one clock later, together with a valid strobe.

There are three merge modes, and all of them use one lane inserter. Zero mode clears every lane except the chosen one. Invert mode returns the bitwise complement of the zero-mode value. Keep mode replaces the chosen lane and leaves the rest of the old value as it was. A narrow (32-bit) destination has only the two low lanes. Its result is always zero-extended to 64 bits. A 32-bit constant is built in two steps: a zero-mode load of the low half, then a keep-mode load of the high half, with the first result fed back as the old value.

An operation is illegal if it names a high lane on a narrow destination or uses the reserved mode code. The unit flags such an operation and does not write the destination.

Top module: `mw_exec`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: Zero mode (`in_mode` = 2'b00) with `in_wide` = 1 gives `in_imm << (16*in_lane)`, with every other lane zero.
- R3: Invert mode (`in_mode` = 2'b01) with `in_wide` = 1 gives `~(in_imm << (16*in_lane))` over all 64 bits.
- R4: Keep mode (`in_mode` = 2'b10) with `in_wide` = 1 gives `in_old` with bits [16*lane+15 : 16*lane] replaced by `in_imm`.
- R5: When `in_wide` = 0, bits [63:32] of the result are zero in every mode. Zero mode places the immediate at lane 0 (bits 15:0) or lane 1 (bits 31:16).
- R6: Invert mode with `in_wide` = 0 complements only the low 32 bits of the zero-mode value. For example, immediate 0x1234 at lane 0 gives 0x00000000_FFFFEDCB.
- R7: Keep mode with `in_wide` = 0 gives bits [31:0] of `in_old` with the chosen lane replaced, and bits [63:32] cleared. Zero mode with 0x1234 at lane 0, followed by keep mode with 0xABCD at lane 1, gives 0x00000000_ABCD1234.
- R8: `out_valid` in each cycle equals the registered value of `in_valid` for a legal operation from the previous cycle. Back-to-back operations each produce their own result one cycle later.
- R9: An operation with `in_wide` = 0 and `in_lane` of 2 or 3, or with `in_mode` = 2'b11, raises `out_illegal` one cycle later. In that cycle `out_valid` is low and `out_result` keeps its previous value.
- R10: In a cycle where `in_valid` is low, the next `out_result` equals the current one, whatever the other inputs are. `out_valid` and `out_illegal` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 2 | Merge mode: 00 zero, 01 invert, 10 keep, 11 reserved |
| in_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| in_lane | input | 2 | Lane index; shift amount is 16 × lane |
| in_imm | input | 16 | Immediate to insert |
| in_old | input | 64 | Current destination value (used by keep mode) |
| out_valid | output | 1 | New destination value is present |
| out_illegal | output | 1 | Previous operation was rejected |
| out_result | output | 64 | Registered destination value |

## Verification
Two checks can fall due in the same cycle: rejecting an illegal operation and holding the result of the legal operation just before it. The bench provokes this by sending a narrow high-lane operation, and then a reserved-mode operation, right after a legal result. It then checks that `out_illegal` rises while `out_result` still equals the earlier value. Keep-mode merging and narrow zero-extension also meet in one cycle when a narrow keep operation gets an old value with its upper half set. The bench judges that case by checking that the upper half of the result is zero while the other low lane survives.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int MW_IMM_W        = 16;
    localparam int MW_LANES        = 4;
    localparam int MW_NARROW_LANES = 2;
    localparam int MW_DATA_W       = MW_IMM_W * MW_LANES;
    localparam int MW_NARROW_W     = MW_IMM_W * MW_NARROW_LANES;
    localparam int MW_SEL_W        = $clog2(MW_LANES);

    typedef enum logic [1:0] {
        MW_ZERO   = 2'b00,
        MW_INVERT = 2'b01,
        MW_KEEP   = 2'b10,
        MW_RSVD   = 2'b11
    } mw_mode_e;

    typedef struct packed {
        logic                 valid;
        mw_mode_e             mode;
        logic                 wide;
        logic [MW_SEL_W-1:0]  lane;
        logic [MW_IMM_W-1:0]  imm;
        logic [MW_DATA_W-1:0] old;
    } mw_req_t;

    function automatic logic mw_is_legal(input mw_mode_e mode, input logic wide,
                                         input logic [MW_SEL_W-1:0] lane);
        logic lane_ok;
        lane_ok = wide || (int'(lane) < MW_NARROW_LANES);
        return lane_ok && (mode != MW_RSVD);
    endfunction

endpackage

// File: rtl/mw_lane_place.sv
module mw_lane_place #(
    parameter int IMM_W = 16,
    parameter int LANES = 4,
    localparam int DW    = IMM_W * LANES,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [SEL_W-1:0] lane,
    output logic [DW-1:0]    placed,
    output logic [DW-1:0]    lane_mask
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = (lane == SEL_W'(g));
        assign placed[g*IMM_W +: IMM_W]    = hit ? imm : '0;
        assign lane_mask[g*IMM_W +: IMM_W] = {IMM_W{hit}};
    end

endmodule

// File: rtl/mw_merge.sv
module mw_merge
    import mw_pkg::*;
#(
    parameter int DW       = 64,
    parameter int NARROW_W = 32
) (
    input  mw_mode_e      mode,
    input  logic          wide,
    input  logic [DW-1:0] placed,
    input  logic [DW-1:0] lane_mask,
    input  logic [DW-1:0] old,
    output logic [DW-1:0] result
);

    logic [DW-1:0] merged;
    logic [DW-1:0] width_mask;

    assign width_mask = wide ? {DW{1'b1}} : {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    always_comb begin
        unique case (mode)
            MW_ZERO:   merged = placed;
            MW_INVERT: merged = ~placed;
            MW_KEEP:   merged = (old & ~lane_mask) | placed;
            default:   merged = '0;
        endcase
    end

    assign result = merged & width_mask;

endmodule

// File: rtl/mw_exec.sv
module mw_exec
    import mw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_mode,
    input  logic                 in_wide,
    input  logic [MW_SEL_W-1:0]  in_lane,
    input  logic [MW_IMM_W-1:0]  in_imm,
    input  logic [MW_DATA_W-1:0] in_old,
    output logic                 out_valid,
    output logic                 out_illegal,
    output logic [MW_DATA_W-1:0] out_result
);

    mw_req_t              req;
    logic [MW_DATA_W-1:0] placed;
    logic [MW_DATA_W-1:0] lane_mask;
    logic [MW_DATA_W-1:0] next_val;
    logic                 legal;

    assign req.valid = in_valid;
    assign req.mode  = mw_mode_e'(in_mode);
    assign req.wide  = in_wide;
    assign req.lane  = in_lane;
    assign req.imm   = in_imm;
    assign req.old   = in_old;

    assign legal = mw_is_legal(req.mode, req.wide, req.lane);

    mw_lane_place #(
        .IMM_W (MW_IMM_W),
        .LANES (MW_LANES)
    ) u_place (
        .imm       (req.imm),
        .lane      (req.lane),
        .placed    (placed),
        .lane_mask (lane_mask)
    );

    mw_merge #(
        .DW       (MW_DATA_W),
        .NARROW_W (MW_NARROW_W)
    ) u_merge (
        .mode      (req.mode),
        .wide      (req.wide),
        .placed    (placed),
        .lane_mask (lane_mask),
        .old       (req.old),
        .result    (next_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid   <= req.valid && legal;
            out_illegal <= req.valid && !legal;
            if (req.valid && legal) begin
                out_result <= next_val;
            end
        end
    end

endmodule

// File: rtl/mw_exec_checker.sv
module mw_exec_checker
    import mw_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [1:0]           in_mode,
    input logic                 in_wide,
    input logic [MW_SEL_W-1:0]  in_lane,
    input logic [MW_IMM_W-1:0]  in_imm,
    input logic [MW_DATA_W-1:0] in_old,
    input logic                 out_valid,
    input logic                 out_illegal,
    input logic [MW_DATA_W-1:0] out_result
);

    logic                 armed;
    logic                 ok_in;
    logic [MW_DATA_W-1:0] lmask;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign ok_in = (in_wide || !in_lane[MW_SEL_W-1]) && (in_mode != 2'b11);
    assign lmask = {{(MW_DATA_W-MW_IMM_W){1'b0}}, {MW_IMM_W{1'b1}}} << (MW_IMM_W * int'(in_lane));

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_illegal && out_result == '0));

    // R8
    p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid && ok_in)));

    // R9
    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && !ok_in)) |->
            (out_illegal && !out_valid && out_result == $past(out_result)));

    // R10
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(in_valid)) |-> ($stable(out_result) && !out_valid && !out_illegal));

    // R5
    p_narrow_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && !$past(in_wide)) |-> (out_result[MW_DATA_W-1:MW_NARROW_W] == '0));

    // R4
    p_keep_other_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_mode == 2'b10 && in_wide)) |->
            ((out_result & ~$past(lmask)) == ($past(in_old) & ~$past(lmask))));

    // R4
    p_keep_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_mode == 2'b10 && in_wide)) |->
            ((out_result & $past(lmask)) ==
             ($past({{(MW_DATA_W-MW_IMM_W){1'b0}}, in_imm} << (MW_IMM_W * int'(in_lane))))));

endmodule

bind mw_exec mw_exec_checker u_mw_exec_checker (.*);

// File: tb/test_mw_exec.sv
module test_mw_exec;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 2 + 1 + 2 + 16 + 64 + 64;
    localparam int NV = 11;

    // {mode, wide, lane, imm, old, expected}
    localparam logic [VW-1:0] VECS [NV] = '{
        {2'b00, 1'b1, 2'd0, 16'h1234, 64'h0, 64'h0000_0000_0000_1234},                    // R2
        {2'b00, 1'b1, 2'd3, 16'hBEEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hBEEF_0000_0000_0000},  // R2
        {2'b01, 1'b1, 2'd0, 16'h1234, 64'h0, 64'hFFFF_FFFF_FFFF_EDCB},                    // R3
        {2'b01, 1'b1, 2'd2, 16'h00FF, 64'h0, 64'hFFFF_FF00_FFFF_FFFF},                    // R3
        {2'b10, 1'b1, 2'd1, 16'hABCD, 64'h1111_2222_3333_4444, 64'h1111_2222_ABCD_4444},  // R4
        {2'b10, 1'b1, 2'd3, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF},  // R4
        {2'b00, 1'b0, 2'd1, 16'h5A5A, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_5A5A_0000},  // R5
        {2'b01, 1'b0, 2'd0, 16'h1234, 64'h0, 64'h0000_0000_FFFF_EDCB},                    // R6
        {2'b01, 1'b0, 2'd1, 16'h0001, 64'h0, 64'h0000_0000_FFFE_FFFF},                    // R6
        {2'b10, 1'b0, 2'd0, 16'h1234, 64'h9999_8888_ABCD_0000, 64'h0000_0000_ABCD_1234},  // R7
        {2'b10, 1'b0, 2'd1, 16'hABCD, 64'hFFFF_FFFF_0000_1234, 64'h0000_0000_ABCD_1234}   // R7
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_mode;
    logic        in_wide;
    logic [1:0]  in_lane;
    logic [15:0] in_imm;
    logic [63:0] in_old;
    logic        out_valid;
    logic        out_illegal;
    logic [63:0] out_result;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_exec i_mw_exec (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_mode     (in_mode),
        .in_wide     (in_wide),
        .in_lane     (in_lane),
        .in_imm      (in_imm),
        .in_old      (in_old),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_result  (out_result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; return at the next falling edge.
    task automatic apply(input logic v, input logic [1:0] m, input logic w,
                         input logic [1:0] l, input logic [15:0] i, input logic [63:0] o);
        in_valid = v; in_mode = m; in_wide = w; in_lane = l; in_imm = i; in_old = o;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1;
        in_valid = 1'b0; in_mode = 2'b00; in_wide = 1'b1; in_lane = 2'd0;
        in_imm = 16'h0; in_old = 64'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid",   {63'h0, out_valid},   64'h0);
        check("R1 illegal", {63'h0, out_illegal}, 64'h0);
        check("R1 result",  out_result,           64'h0);
        rst = 1'b0;

        // Vector walk
        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = VECS[k];
            apply(1'b1, v[148:147], v[146], v[145:144], v[143:128], v[127:64]);
            check($sformatf("R8 vec%0d valid", k), {63'h0, out_valid}, 64'h1);
            check($sformatf("R2-7 vec%0d result", k), out_result, v[63:0]);
            apply(1'b0, 2'b00, 1'b1, 2'd0, 16'h0, 64'h0);
        end

        // R7: two-step narrow constant build with feedback
        apply(1'b1, 2'b00, 1'b0, 2'd0, 16'h1234, 64'hDEAD_BEEF_DEAD_BEEF);
        check("R7 step1", out_result, 64'h0000_0000_0000_1234);
        apply(1'b1, 2'b10, 1'b0, 2'd1, 16'hABCD, out_result);
        check("R7 step2", out_result, 64'h0000_0000_ABCD_1234);

        // R8: back-to-back operations
        apply(1'b1, 2'b00, 1'b1, 2'd2, 16'h7777, 64'h0);
        check("R8 b2b first", out_result, 64'h0000_7777_0000_0000);
        apply(1'b1, 2'b01, 1'b1, 2'd1, 16'hFFFF, 64'h0);
        check("R8 b2b second", out_result, 64'hFFFF_FFFF_0000_FFFF);
        check("R8 b2b valid", {63'h0, out_valid}, 64'h1);
        held = out_result;

        // R9: narrow high lane rejected right after a legal result
        apply(1'b1, 2'b00, 1'b0, 2'd2, 16'h1111, 64'h0);
        check("R9 lane illegal flag", {63'h0, out_illegal}, 64'h1);
        check("R9 lane valid low",    {63'h0, out_valid},   64'h0);
        check("R9 lane result held",  out_result,           held);
        apply(1'b1, 2'b10, 1'b0, 2'd3, 16'h2222, 64'h5555_5555_5555_5555);
        check("R9 lane3 flag",        {63'h0, out_illegal}, 64'h1);
        check("R9 lane3 result held", out_result,           held);
        // R9: reserved mode
        apply(1'b1, 2'b11, 1'b1, 2'd0, 16'h3333, 64'h0);
        check("R9 mode flag",        {63'h0, out_illegal}, 64'h1);
        check("R9 mode valid low",   {63'h0, out_valid},   64'h0);
        check("R9 mode result held", out_result,           held);

        // R10: idle cycles with busy inputs
        apply(1'b0, 2'b01, 1'b1, 2'd3, 16'hAAAA, 64'h1234_5678_9ABC_DEF0);
        check("R10 idle result",  out_result,           held);
        check("R10 idle valid",   {63'h0, out_valid},   64'h0);
        check("R10 idle illegal", {63'h0, out_illegal}, 64'h0);
        apply(1'b0, 2'b10, 1'b0, 2'd1, 16'h5555, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 idle result 2", out_result, held);

        // R1: reset mid-run clears outputs
        rst = 1'b1;
        apply(1'b1, 2'b00, 1'b1, 2'd0, 16'h4444, 64'h0);
        check("R1 rerun result", out_result, 64'h0);
        check("R1 rerun valid",  {63'h0, out_valid}, 64'h0);
        rst = 1'b0;
        apply(1'b0, 2'b00, 1'b1, 2'd0, 16'h0, 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule